// File: doc/BRIEF.md
# Quarter-Phase Duty Comparator for Four PWM Channels

This block turns one shared 12-bit period timer into four edge-aligned PWM outputs. The duty time of each output can be set more finely than one timer count. Each system clock carries a 2-bit phase code, and four phases make up one timer count. Each channel holds a 14-bit duty value. Its upper 12 bits name the timer count on which the active time ends, and its lower 2 bits name the phase inside that count. When the timer prescaler is not 1:1, the phase bits are ignored and the match always lands on the first phase.

Software loads a duty value through an 8-bit byte port, selecting the channel and which byte is written. The high byte is parked in a holding register. The later low-byte write commits both bytes to the staging copy in one step. The staging copy moves to the active copy only at a period start, which is timer 0 in phase code 00. A value changed in mid-period therefore takes effect in the following period.

Top module: `qpwm_cmp`

## Requirements
- R1: While reset is held, and on the first clock after reset with no duty loaded, every output is low. All duty, staging and holding registers clear to zero.
- R2: A high-byte write (`wr_hi`=1) only updates the holding register for the selected channel. A low-byte write (`wr_hi`=0) loads that channel's staging value with {held high bits, low byte} in one step. A high-byte write on its own leaves the staging value unchanged.
- R3: Bits 7:6 of a high-byte write are discarded. The duty value is 14 bits: held bits 5:0 form duty 13:8, and the low byte forms duty 7:0.
- R4: The staging value becomes the active value only in the cycle with timer = 0 and phase code 00. A write made in mid-period does not change the current period's output.
- R5: In the period-start cycle, an output whose duty value is not matched in that same cycle goes high. Each output is a register, so it reflects the cycle's decision one clock later.
- R6: With `pre_1to1`=1, the output goes low in the cycle where timer = duty[13:2] and phase = duty[1:0]. Phase codes 00, 01, 10 and 11 are the first to fourth phases. When the timer steps every four clocks, the output is high for exactly `duty` clocks.
- R7: With `pre_1to1`=0, duty[1:0] is ignored, and the output goes low in the phase-00 cycle where timer = duty[13:2].
- R8: A duty value of zero keeps the output low for the whole period. This also holds when `pre_1to1`=0 and duty[13:2] = 0.
- R9: A duty value whose upper bits are never reached by the timer keeps the output high until the next period start.
- R10: The four channels are independent. A write to one channel changes no other channel's output.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock, one phase per cycle |
| rst_n | input | 1 | Synchronous active-low reset |
| tmr_val | input | 12 | Shared period timer value |
| phase | input | 2 | Phase code 00..11 inside the current timer count |
| pre_1to1 | input | 1 | 1 when the timer prescaler is 1:1 (phase bits of duty used) |
| wr_en | input | 1 | Duty byte write strobe |
| wr_hi | input | 1 | 1 writes the high byte, 0 writes the low byte and commits |
| wr_ch | input | 2 | Channel selected by the write |
| wr_data | input | 8 | Byte written |
| pwm_out | output | 4 | Active-high PWM output per channel |

## Verification
Two events can fall in the same cycle: the period start, which turns the output on, and the duty match, which turns it off. This happens whenever a duty value is zero, or when `pre_1to1`=0 and duty[13:2] = 0. The bench loads such values on purpose, including values with non-zero phase bits. It requires the output to stay low for the whole period, so the match wins. A staging write and a period-start transfer also meet, in the sense that writes are made in the middle of periods. The bench judges these by requiring the changed value to show up only in the following period.

// File: rtl/qpwm_pkg.sv
// Package: shared widths and types for the quarter-phase duty comparator.
// Assumes the duty word is the timer width plus the phase-select width.
package qpwm_pkg;
    localparam int TMR_W  = 12;
    localparam int FINE_W = 2;
    localparam int BYTE_W = 8;
    localparam int DUTY_W = TMR_W + FINE_W;
    localparam int HI_W   = DUTY_W - BYTE_W;
    typedef logic [DUTY_W-1:0] duty_t;
    typedef logic [TMR_W-1:0]  tmr_t;
    typedef logic [FINE_W-1:0] phase_t;
endpackage

// File: rtl/qpwm_duty_buf.sv
// Module: one channel's duty storage: high-byte hold, staging copy, active copy.
// A low-byte write commits {hold, low byte} to staging in one step. Staging
// moves to active on the period-start cycle. eff_duty is the value in force
// for the current cycle: the staged value on a period start, else the active one.
module qpwm_duty_buf
    import qpwm_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_en,
    input  logic              wr_hi,
    input  logic [BYTE_W-1:0] wr_data,
    input  logic              per_start,
    output duty_t             eff_duty
);
    logic [HI_W-1:0] hold_q;
    duty_t           stage_q;
    duty_t           active_q;

    // Park the high byte; its unused upper bits are dropped here.
    always_ff @(posedge clk) begin
        if (!rst_n)                hold_q <= '0;
        else if (wr_en && wr_hi)   hold_q <= wr_data[HI_W-1:0];
    end

    // Commit the full staging word on a low-byte write.
    always_ff @(posedge clk) begin
        if (!rst_n)                stage_q <= '0;
        else if (wr_en && !wr_hi)  stage_q <= {hold_q, wr_data};
    end

    // Transfer staging to active at a period start only.
    always_ff @(posedge clk) begin
        if (!rst_n)                active_q <= '0;
        else if (per_start)        active_q <= stage_q;
    end

    // Value that the comparator uses in this cycle.
    always_comb eff_duty = per_start ? stage_q : active_q;

    p_active_hold_r4: assert property (@(posedge clk) disable iff (!rst_n)
        !per_start |=> $stable(active_q));
    p_hi_only_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && wr_hi) |=> $stable(stage_q));
    p_lo_commit_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && !wr_hi) |=> (stage_q[BYTE_W-1:0] == $past(wr_data)));
    p_hi_bits_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && !wr_hi) |=> (stage_q[DUTY_W-1:BYTE_W] == $past(hold_q)));
endmodule

// File: rtl/qpwm_chan_cmp.sv
// Module: one channel's duty comparator and output register.
// Assumes the phase code advances once per clock. A match clears the output,
// and a period start sets it. When both fall in one cycle, the match wins,
// so a zero duty stays low. With fine_en low, the phase-select bits are ignored.
module qpwm_chan_cmp
    import qpwm_pkg::*;
(
    input  logic   clk,
    input  logic   rst_n,
    input  duty_t  eff_duty,
    input  tmr_t   tmr_val,
    input  phase_t phase,
    input  logic   fine_en,
    input  logic   per_start,
    output logic   pwm
);
    logic   coarse_eq;
    phase_t want_phase;
    logic   hit;

    // Coarse compare plus the phase that the match must land on.
    always_comb begin
        coarse_eq  = (eff_duty[DUTY_W-1:FINE_W] == tmr_val);
        want_phase = fine_en ? eff_duty[FINE_W-1:0] : '0;
        hit        = coarse_eq && (phase == want_phase);
    end

    // Output register: the match clears, the period start sets, otherwise hold.
    always_ff @(posedge clk) begin
        if (!rst_n)          pwm <= 1'b0;
        else if (hit)        pwm <= 1'b0;
        else if (per_start)  pwm <= 1'b1;
    end

    p_start_high_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (per_start && !hit) |=> pwm);
    p_match_low_r6: assert property (@(posedge clk) disable iff (!rst_n)
        hit |=> !pwm);
    p_hold_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (!per_start && !hit) |=> $stable(pwm));
endmodule

// File: rtl/qpwm_cmp.sv
// Module: top of the four-channel quarter-phase PWM comparator.
// Assumes the timer and phase come from an external time base. The period
// starts at timer 0 in phase code 00. Only one byte is written per cycle.
module qpwm_cmp
    import qpwm_pkg::*;
#(
    parameter int NUM_CH = 4,
    localparam int CH_W  = (NUM_CH > 1) ? $clog2(NUM_CH) : 1
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [TMR_W-1:0]  tmr_val,
    input  logic [FINE_W-1:0] phase,
    input  logic              pre_1to1,
    input  logic              wr_en,
    input  logic              wr_hi,
    input  logic [CH_W-1:0]   wr_ch,
    input  logic [BYTE_W-1:0] wr_data,
    output logic [NUM_CH-1:0] pwm_out
);
    logic per_start;

    // Period start: first phase of timer count zero.
    always_comb per_start = (tmr_val == '0) && (phase == '0);

    for (genvar g = 0; g < NUM_CH; g++) begin : g_ch
        duty_t eff_duty;
        logic  sel_wr;

        // Route the shared write strobe to this channel only.
        always_comb sel_wr = wr_en && (wr_ch == CH_W'(g));

        qpwm_duty_buf u_buf (
            .clk       (clk),
            .rst_n     (rst_n),
            .wr_en     (sel_wr),
            .wr_hi     (wr_hi),
            .wr_data   (wr_data),
            .per_start (per_start),
            .eff_duty  (eff_duty)
        );

        qpwm_chan_cmp u_cmp (
            .clk       (clk),
            .rst_n     (rst_n),
            .eff_duty  (eff_duty),
            .tmr_val   (tmr_val),
            .phase     (phase),
            .fine_en   (pre_1to1),
            .per_start (per_start),
            .pwm       (pwm_out[g])
        );

        p_coarse_fall_r7: assert property (@(posedge clk) disable iff (!rst_n)
            ($fell(pwm_out[g]) && !$past(pre_1to1)) |-> ($past(phase) == '0));
        p_rise_at_start_r5: assert property (@(posedge clk) disable iff (!rst_n)
            $rose(pwm_out[g]) |-> $past(per_start));
    end
endmodule

// File: tb/qpwm_cmp_tb_top.sv
module qpwm_cmp_tb_top;
    localparam int NCH  = 4;
    localparam int MAXS = 256;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic [11:0] tmr_val = '0;
    logic [1:0] phase = '0;
    logic       pre_1to1 = 1'b1;
    logic       wr_en = 1'b0;
    logic       wr_hi = 1'b0;
    logic [1:0] wr_ch = '0;
    logic [7:0] wr_data = '0;
    logic [3:0] pwm_out;

    int checks = 0;
    int errors = 0;
    bit done = 1'b0;

    // Reference state built from the requirements: hold, staging, active.
    logic [5:0]  m_hold  [NCH];
    logic [13:0] m_stage [NCH];
    logic [13:0] m_act   [NCH];

    // Writes queued for the next period.
    int         wq_n = 0;
    logic [1:0] wq_ch [8];
    logic       wq_hi [8];
    logic [7:0] wq_d  [8];

    always #5 clk = ~clk;

    qpwm_cmp dut_i (
        .clk(clk), .rst_n(rst_n), .tmr_val(tmr_val), .phase(phase),
        .pre_1to1(pre_1to1), .wr_en(wr_en), .wr_hi(wr_hi), .wr_ch(wr_ch),
        .wr_data(wr_data), .pwm_out(pwm_out)
    );

    // Expected count of high clocks in a period of p timer counts (R6-R9 rules).
    function automatic int exp_len(logic [13:0] d, int p, bit fine);
        int u = int'(d[13:2]);
        if (d == 14'd0) return 0;
        if (!fine && u == 0) return 0;
        if (u >= p) return 4 * p;
        return fine ? int'(d) : 4 * u;
    endfunction

    task automatic chk(string req, int act, int exp);
        checks++;
        if (act != exp) begin
            errors++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    task automatic qwr(int ch, bit hi, logic [7:0] d);
        wq_ch[wq_n] = 2'(ch); wq_hi[wq_n] = hi; wq_d[wq_n] = d; wq_n++;
    endtask

    task automatic wr_duty(int ch, logic [13:0] d);
        qwr(ch, 1'b1, {2'b00, d[13:8]});
        qwr(ch, 1'b0, d[7:0]);
    endtask

    // Run one period of p timer counts, apply the queued writes, and check the waveforms.
    task automatic run_period(int p, bit fine, string tag);
        logic [MAXS-1:0] smp [NCH];
        int k = 0;
        for (int c = 0; c < NCH; c++) begin
            m_act[c] = m_stage[c];
            smp[c] = '0;
        end
        pre_1to1 = fine;
        for (int t = 0; t < p; t++) begin
            for (int ph = 0; ph < 4; ph++) begin
                tmr_val = 12'(t);
                phase = 2'(ph);
                if (k >= 1 && k <= wq_n) begin
                    int w = k - 1;
                    wr_en = 1'b1; wr_hi = wq_hi[w]; wr_ch = wq_ch[w]; wr_data = wq_d[w];
                    if (wq_hi[w]) m_hold[wq_ch[w]] = wq_d[w][5:0];
                    else m_stage[wq_ch[w]] = {m_hold[wq_ch[w]], wq_d[w]};
                end else begin
                    wr_en = 1'b0;
                end
                @(negedge clk);
                for (int c = 0; c < NCH; c++) smp[c][k] = pwm_out[c];
                k++;
            end
        end
        wr_en = 1'b0;
        wq_n = 0;
        for (int c = 0; c < NCH; c++) begin
            int n = exp_len(m_act[c], p, fine);
            int bad = -1;
            for (int s = 0; s < 4 * p; s++)
                if (smp[c][s] != (s < n)) begin bad = s; break; end
            chk($sformatf("%s ch%0d duty=%0d p=%0d fine=%0d first-bad-sample", tag, c,
                          m_act[c], p, fine), bad, -1);
        end
    endtask

    initial begin
        void'($urandom(32'd2024));
        for (int c = 0; c < NCH; c++) begin
            m_hold[c] = '0; m_stage[c] = '0; m_act[c] = '0;
        end
        repeat (3) @(negedge clk);
        chk("R1 outputs in reset", int'(pwm_out), 0);
        rst_n = 1'b1;
        // R1: the first period after reset with nothing loaded stays low.
        wr_duty(0, 14'd9); wr_duty(1, 14'd1); wr_duty(2, 14'd22);
        run_period(4, 1'b1, "R1");
        // R6: every phase code, plus R9 for a value past the period end.
        wr_duty(3, 14'd400);
        run_period(8, 1'b1, "R6");
        // R8 / R7: zero duty, and coarse mode with upper bits zero but phase bits set.
        wr_duty(0, 14'd0); wr_duty(1, 14'd3);
        run_period(8, 1'b1, "R6");
        run_period(8, 1'b0, "R8");
        run_period(6, 1'b1, "R9");
        // R2: a high byte alone must not change the staging value.
        qwr(2, 1'b1, 8'h01);
        run_period(6, 1'b1, "R2");
        run_period(6, 1'b1, "R2");
        // R3: the top bits of the high byte are dropped (0xC0 -> 0).
        wr_duty(2, 14'd0);
        qwr(2, 1'b1, 8'hC0); qwr(2, 1'b0, 8'd13);
        run_period(6, 1'b1, "R3");
        run_period(6, 1'b1, "R3");
        // R4 / R10: change only channel 1 mid-period.
        wr_duty(1, 14'd17);
        run_period(7, 1'b1, "R4");
        run_period(7, 1'b1, "R10");
        run_period(7, 1'b0, "R7");
        // Random duties, periods and prescaler modes.
        for (int i = 0; i < 120; i++) begin
            int p = 2 + int'($urandom_range(0, 30));
            bit f = bit'($urandom_range(0, 1));
            for (int j = 0; j < 2; j++) begin
                int ch = int'($urandom_range(0, 3));
                wr_duty(ch, 14'($urandom_range(0, 4 * 34)));
            end
            run_period(p, f, f ? "R6" : "R7");
        end
        done = 1'b1;
    end

    initial begin
        fork
            wait (done);
            begin
                repeat (150000) @(posedge clk);
                errors++;
                $display("FAIL watchdog actual=%0d expected=%0d", 0, 1);
            end
        join_any
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule